// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking a two-level page table in memory. A request gives the logical address and the byte address of the root (outer) table. The walker reads one outer entry, which names the 4 KB page that holds the inner table. It then reads one inner entry, which names the physical frame. The page offset is placed below that frame number. If either entry is marked not valid, the walk stops and a fault is reported together with the level that failed.

The logical address splits into three fields. Bits 31:22 index the outer table. Bits 21:12 index the inner table. Bits 11:0 are the byte offset inside the page. Each table entry is 32 bits wide: bits 31:12 hold a frame number and bit 0 is the valid flag. Bits 11:1 carry no meaning. An entry sits at its table base plus four times its index.

Memory is reached through one read port. A read request uses a valid/ready handshake. At most one read is outstanding, and its data comes back on a response strobe. The walker takes a new request only while idle. It has no translation cache, does not check permissions and never writes to the tables.

Top module: `tbl_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `mem_rd_valid` and `rsp_valid` are 0.
- R2: The first read of a walk goes to `req_root + 4 * vaddr[31:22]`.
- R3: When the outer entry is valid, the second read goes to `{outer_entry[31:12], vaddr[21:12], 2'b00}`.
- R4: When both entries are valid, `rsp_paddr` is `{inner_entry[31:12], vaddr[11:0]}` and `rsp_fault` is 0.
- R5: When bit 0 of the outer entry is 0, the walk ends with `rsp_fault`=1 and `rsp_fault_lvl`=0, and no second read is issued.
- R6: When bit 0 of the inner entry is 0, the walk ends with `rsp_fault`=1 and `rsp_fault_lvl`=1.
- R7: A read request holds `mem_rd_valid` and `mem_rd_addr` steady until it is accepted. No new read is requested until the response to the previous read has arrived. A walk issues at most two reads.
- R8: A request is accepted only while `req_ready` is 1. A request presented during a walk is ignored: it does not change that walk's result, and it does not start another walk.
- R9: `rsp_valid` is high for exactly one cycle per walk. In the cycle after it, `req_ready` is 1 again.
- R10: Entry bits 11:1 have no effect on either read address or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Logical address to translate |
| req_root | input | 32 | Byte address of the outer table |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Result pulse, one cycle |
| rsp_paddr | output | 32 | Physical address, meaningful when there is no fault |
| rsp_fault | output | 1 | Walk ended on an entry that is not valid |
| rsp_fault_lvl | output | 1 | Level that failed: 0 outer, 1 inner |

## Verification
The hardest case to reach from the ports is a second request that arrives while a walk is still in progress. The walker must ignore it, so nothing changes at the outputs. To make this visible, the bench keeps the read response late for several cycles. During that window it drives a different logical address with `req_valid` held high, and it removes that request before the walker returns to idle. The bench then checks three things: the result matches the first address, the walk made exactly two reads, and no further read or result pulse follows. Read-port back-pressure and response latency are varied per scenario, so that the hold and single-outstanding rules are tested at every wait length.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [1:0] {
        TW_IDLE   = 2'd0,
        TW_OUTER  = 2'd1,
        TW_INNER  = 2'd2,
        TW_FINISH = 2'd3
    } tw_state_e;

    typedef enum logic {
        TW_LVL_OUTER = 1'b0,
        TW_LVL_INNER = 1'b1
    } tw_level_e;

    localparam int unsigned TW_VALID_BIT = 0;

endpackage

// File: rtl/tw_addr_split.sv
module tw_addr_split #(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned IDX_W = 10,
    parameter int unsigned OFF_W = 12
) (
    input  logic [VA_W-1:0]  vaddr,
    output logic [IDX_W-1:0] outer_idx,
    output logic [IDX_W-1:0] inner_idx,
    output logic [OFF_W-1:0] offset
);
    localparam int unsigned INNER_LO = OFF_W;
    localparam int unsigned OUTER_LO = OFF_W + IDX_W;

    assign offset    = vaddr[OFF_W-1:0];
    assign inner_idx = vaddr[INNER_LO +: IDX_W];
    assign outer_idx = vaddr[OUTER_LO +: IDX_W];
endmodule

// File: rtl/tw_entry_dec.sv
module tw_entry_dec #(
    parameter int unsigned ENT_W = 32,
    parameter int unsigned OFF_W = 12
) (
    input  logic [ENT_W-1:0]       entry,
    output logic [ENT_W-OFF_W-1:0] frame,
    output logic                   present
);
    import tw_pkg::*;

    logic unused_rsv;

    assign frame      = entry[ENT_W-1:OFF_W];
    assign present    = entry[TW_VALID_BIT];
    // R10: the bits between the flag and the frame number are not decoded
    assign unused_rsv = ^entry[OFF_W-1:TW_VALID_BIT+1];
endmodule

// File: rtl/tw_entry_addr.sv
module tw_entry_addr #(
    parameter int unsigned AW    = 32,
    parameter int unsigned IDX_W = 10,
    parameter int unsigned ENT_W = 32
) (
    input  logic [AW-1:0]    base,
    input  logic [IDX_W-1:0] idx,
    output logic [AW-1:0]    addr
);
    localparam int unsigned ENT_SH = $clog2(ENT_W / 8);

    assign addr = base + (AW'(idx) << ENT_SH);
endmodule

// File: rtl/tbl_walker.sv
module tbl_walker #(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned IDX_W = 10,
    parameter int unsigned OFF_W = 12,
    parameter int unsigned ENT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [ENT_W-1:0] req_root,
    output logic             mem_rd_valid,
    input  logic             mem_rd_ready,
    output logic [ENT_W-1:0] mem_rd_addr,
    input  logic             mem_rsp_valid,
    input  logic [ENT_W-1:0] mem_rsp_data,
    output logic             rsp_valid,
    output logic [ENT_W-1:0] rsp_paddr,
    output logic             rsp_fault,
    output logic             rsp_fault_lvl
);
    import tw_pkg::*;

    localparam int unsigned AW    = ENT_W;
    localparam int unsigned FRM_W = ENT_W - OFF_W;

    typedef struct packed {
        tw_state_e       state;
        logic            issued;
        logic [VA_W-1:0] vaddr;
        logic [AW-1:0]   base;
        logic [AW-1:0]   paddr;
        logic            fault;
        tw_level_e       lvl;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    logic [IDX_W-1:0] outer_idx, inner_idx, cur_idx;
    logic [OFF_W-1:0] pg_off;
    logic [FRM_W-1:0] ent_frame;
    logic             ent_present;
    logic             at_table;

    tw_addr_split #(.VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
        .vaddr     (r_q.vaddr),
        .outer_idx (outer_idx),
        .inner_idx (inner_idx),
        .offset    (pg_off)
    );

    tw_entry_dec #(.ENT_W(ENT_W), .OFF_W(OFF_W)) u_dec (
        .entry   (mem_rsp_data),
        .frame   (ent_frame),
        .present (ent_present)
    );

    assign cur_idx = (r_q.state == TW_OUTER) ? outer_idx : inner_idx;

    tw_entry_addr #(.AW(AW), .IDX_W(IDX_W), .ENT_W(ENT_W)) u_eaddr (
        .base (r_q.base),
        .idx  (cur_idx),
        .addr (mem_rd_addr)
    );

    assign at_table = (r_q.state == TW_OUTER) || (r_q.state == TW_INNER);

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            TW_IDLE: begin
                if (req_valid) begin
                    r_d.state  = TW_OUTER;
                    r_d.issued = 1'b0;
                    r_d.vaddr  = req_vaddr;
                    r_d.base   = req_root;
                    r_d.paddr  = '0;
                    r_d.fault  = 1'b0;
                    r_d.lvl    = TW_LVL_OUTER;
                end
            end
            TW_OUTER, TW_INNER: begin
                if (!r_q.issued) begin
                    if (mem_rd_ready) r_d.issued = 1'b1;
                end else if (mem_rsp_valid) begin
                    if (!ent_present) begin
                        r_d.state = TW_FINISH;
                        r_d.fault = 1'b1;
                        r_d.lvl   = (r_q.state == TW_INNER) ? TW_LVL_INNER : TW_LVL_OUTER;
                    end else if (r_q.state == TW_OUTER) begin
                        r_d.state  = TW_INNER;
                        r_d.issued = 1'b0;
                        r_d.base   = {ent_frame, {OFF_W{1'b0}}};
                    end else begin
                        r_d.state = TW_FINISH;
                        r_d.paddr = {ent_frame, pg_off};
                    end
                end
            end
            default: r_d.state = TW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: TW_IDLE, issued: 1'b0, vaddr: '0, base: '0,
                     paddr: '0, fault: 1'b0, lvl: TW_LVL_OUTER};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready     = (r_q.state == TW_IDLE);
    assign mem_rd_valid  = at_table && !r_q.issued;
    assign rsp_valid     = (r_q.state == TW_FINISH);
    assign rsp_paddr     = r_q.paddr;
    assign rsp_fault     = r_q.fault;
    assign rsp_fault_lvl = r_q.lvl;

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R7
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && mem_rd_ready) |=> !mem_rd_valid);

    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R8
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !rsp_valid));

    // R4
    ok_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == pg_off));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_rd_valid && !rsp_valid));
endmodule

// File: tb/tbl_walker_bench.sv
`timescale 1ns/1ps
module tbl_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_root = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic        rsp_fault_lvl;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    tbl_walker u_tbl_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_root(req_root),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl)
    );

    // memory model configuration
    logic [31:0] cfg_oaddr, cfg_odata, cfg_iaddr, cfg_idata;
    int          cfg_lat = 0;
    int          cfg_wait = 0;
    int          n_reads = 0;
    int          n_rsp = 0;
    logic [31:0] seen_addr [4];
    bit          pending = 0;
    int          lat_cnt = 0;
    int          wait_cnt = 0;
    logic [31:0] pend_addr;

    function automatic logic [31:0] lookup(input logic [31:0] a);
        if (a == cfg_oaddr) return cfg_odata;
        if (a == cfg_iaddr) return cfg_idata;
        return 32'h0;
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid) n_rsp++;
            mem_rsp_valid = 1'b0;
            if (pending) begin
                if (lat_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = lookup(pend_addr);
                    pending = 0;
                end else lat_cnt--;
            end
            mem_rd_ready = mem_rd_valid && (wait_cnt == 0);
            if (mem_rd_valid && wait_cnt != 0) wait_cnt--;
            if (mem_rd_valid && mem_rd_ready) begin
                if (n_reads < 4) seen_addr[n_reads] = mem_rd_addr;
                n_reads++;
                pending   = 1;
                lat_cnt   = cfg_lat;
                wait_cnt  = cfg_wait;
                pend_addr = mem_rd_addr;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [31:0] got_paddr;
    logic        got_fault, got_lvl;

    // runs one walk; poke>0 keeps a second request on the port for that many cycles
    task automatic walk(input logic [31:0] root, input logic [31:0] va,
                        input logic [31:0] odata, input logic [31:0] idata,
                        input int lat, input int wt, input int poke);
        bit got = 0;
        cfg_oaddr = root + {20'h0, va[31:22], 2'b00};
        cfg_iaddr = {odata[31:12], va[21:12], 2'b00};
        cfg_odata = odata;
        cfg_idata = idata;
        cfg_lat   = lat;
        cfg_wait  = wt;
        wait_cnt  = wt;
        n_reads   = 0;
        n_rsp     = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_root  = root;
        @(negedge clk);
        if (poke > 0) begin
            req_vaddr = ~va;
            req_root  = root ^ 32'h0000_5000;
            repeat (poke) @(negedge clk);
        end
        req_valid = 1'b0;
        for (int i = 0; i < 400 && !got; i++) begin
            if (rsp_valid) begin
                got = 1;
                got_paddr = rsp_paddr;
                got_fault = rsp_fault;
                got_lvl   = rsp_fault_lvl;
            end else @(negedge clk);
        end
        check(got, "R9 result pulse seen", {31'h0, got}, 32'h1);
        @(negedge clk);
        // R9: pulse lasts one cycle and the walker is idle right after
        check(!rsp_valid && req_ready, "R9 one-cycle pulse then idle",
              {30'h0, rsp_valid, req_ready}, 32'h1);
    endtask

    task automatic t_reset;
        // R1
        check(req_ready == 1'b1, "R1 req_ready after reset", {31'h0, req_ready}, 32'h1);
        check(!mem_rd_valid, "R1 no read after reset", {31'h0, mem_rd_valid}, 32'h0);
        check(!rsp_valid, "R1 no result after reset", {31'h0, rsp_valid}, 32'h0);
    endtask

    task automatic t_ok(input logic [31:0] root, input logic [31:0] va,
                        input logic [31:0] odata, input logic [31:0] idata,
                        input int lat, input int wt, input string tag);
        logic [31:0] exp_o, exp_i, exp_p;
        exp_o = root + {20'h0, va[31:22], 2'b00};
        exp_i = {odata[31:12], va[21:12], 2'b00};
        exp_p = {idata[31:12], va[11:0]};
        walk(root, va, odata, idata, lat, wt, 0);
        check(seen_addr[0] == exp_o, {"R2 outer addr ", tag}, seen_addr[0], exp_o);
        check(seen_addr[1] == exp_i, {"R3 inner addr ", tag}, seen_addr[1], exp_i);
        check(!got_fault && got_paddr == exp_p, {"R4 paddr ", tag}, got_paddr, exp_p);
        check(n_reads == 2, {"R7 read count ", tag}, n_reads, 2);
    endtask

    task automatic t_outer_fault;
        walk(32'h0004_0000, 32'h1234_5678, 32'h0009_9FFE, 32'h0007_7001, 1, 1, 0);
        // R5
        check(got_fault && got_lvl == 1'b0, "R5 outer fault level 0", {30'h0, got_fault, got_lvl}, 32'h2);
        check(n_reads == 1, "R5 no inner read after outer fault", n_reads, 1);
    endtask

    task automatic t_inner_fault;
        walk(32'h0008_0000, 32'hCAFE_B123, 32'h0011_1001, 32'h0022_2FFE, 0, 2, 0);
        // R6
        check(got_fault && got_lvl == 1'b1, "R6 inner fault level 1", {30'h0, got_fault, got_lvl}, 32'h3);
        check(n_reads == 2, "R6 both levels read", n_reads, 2);
    endtask

    task automatic t_busy_ignored;
        logic [31:0] va, exp_p;
        va = 32'h5A5A_3C3C;
        exp_p = {20'hABCDE, va[11:0]};
        walk(32'h0010_0000, va, 32'h0033_3001, 32'hABCD_E001, 4, 0, 3);
        // R8
        check(!got_fault && got_paddr == exp_p, "R8 busy request leaves result", got_paddr, exp_p);
        repeat (6) @(negedge clk);
        check(n_reads == 2, "R8 no second walk started", n_reads, 2);
        check(n_rsp == 1, "R8 single result pulse", n_rsp, 1);
    endtask

    initial begin
        #(4 * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_ok(32'h0001_0000, 32'h0040_3ABC, 32'h0002_0001, 32'h0003_4001, 0, 0, "plain");
        t_ok(32'h0001_0004, 32'hFFFF_FFFF, 32'hFFFF_F001, 32'h1234_5001, 2, 3, "all ones stalled");
        t_ok(32'h0000_0000, 32'h0000_0000, 32'h0000_1001, 32'h0000_2001, 5, 1, "zero");
        // R10: reserved entry bits all set
        t_ok(32'h0020_0000, 32'h8123_4567, 32'h0055_5FFF, 32'h0066_6FFF, 1, 0, "R10 reserved bits");
        t_outer_fault();
        t_inner_fault();
        t_busy_ignored();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule